// File: doc/BRIEF.md
# Sync Error Rate Monitor

This block watches the outcome of horizontal sync detection line by line and raises a warning when sync errors arrive too often. A digital leaky bucket does the integration. Each reported sync error adds a fixed weight to an accumulator. Each line strobe drains a programmable leak amount. The accumulator is clamped at zero and at a programmable ceiling.

The warning flag compares against two levels. It rises when the updated accumulator reaches the set level. It falls only when the accumulator drops below a lower clear level, so the flag does not chatter when the rate sits near the trip point. With a weight of 10 and a leak of 1, the balance point is about one error every ten lines. A missed or misplaced sync is reported on `sync_err` as a one-cycle pulse. `line_stb` pulses once for each expected line.

Top module: `sync_err_monitor`

## Requirements
- R1: A synchronous active-low reset clears the accumulator to 0 and drives `warn` low.
- R2: A cycle with `sync_err` high and `line_stb` low raises the accumulator by ERR_WEIGHT (default 10).
- R3: A cycle with `line_stb` high and `sync_err` low lowers the accumulator by `leak_amt`. The result never goes below 0.
- R4: When `sync_err` and `line_stb` are both high in one cycle, both updates apply (net ERR_WEIGHT minus `leak_amt`), then the limits are applied.
- R5: The accumulator never exceeds `acc_max`. An update that would pass it leaves the value at `acc_max`, and lowering `acc_max` pulls a larger value down to it.
- R6: On the clock edge that commits an accumulator value at or above `set_lvl`, `warn` goes high (visible after that same edge).
- R7: `warn` goes low on the edge that commits a value below `clr_lvl`. For values from `clr_lvl` up to `set_lvl` minus one, it keeps its previous state.
- R8: If the levels are misprogrammed so that a value both reaches `set_lvl` and lies below `clr_lvl`, setting wins and `warn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse per expected line |
| sync_err | input | 1 | One-cycle pulse per sync error |
| leak_amt | input | LEAK_W (4) | Amount drained per line strobe |
| set_lvl | input | ACC_W (8) | Level at which the warning rises |
| clr_lvl | input | ACC_W (8) | Level below which the warning falls |
| acc_max | input | ACC_W (8) | Accumulator ceiling |
| warn | output | 1 | Active-high sync warning |

## Verification
The accumulator is visible only through `warn`, so the bench moves the set and clear levels to probe it.

A wrong accumulator value shows up as a flag edge on the wrong line. This appears one edge after the update that crosses a level, or one edge after a level is moved across the held value.

A floor that wraps shows up right away. After the bucket drains, a single error with the set level at ERR_WEIGHT must still raise the flag on that edge. A missing ceiling shows up as a delayed fall once errors stop.

## File: rtl/sem_pkg.sv
// File: rtl/sem_pkg.sv
// Shared definitions for the sync error rate monitor.
package sem_pkg;
    // Kind of accumulator update selected in a cycle.
    typedef enum logic [1:0] {
        UPD_HOLD = 2'b00,
        UPD_LEAK = 2'b01,
        UPD_ADD  = 2'b10,
        UPD_BOTH = 2'b11
    } upd_kind_e;
endpackage

// File: rtl/sem_bucket.sv
// Leaky-bucket accumulator.
// Adds WEIGHT on an error and drains leak on a line strobe.
// Clamps the result to [0, acc_max].
// Assumes WEIGHT fits in ACC_W bits.
// Exposes the committed value and the value to be committed next.
module sem_bucket #(
    parameter int ACC_W  = 8,
    parameter int LEAK_W = 4,
    parameter int WEIGHT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_i,
    input  logic              leak_i,
    input  logic [LEAK_W-1:0] leak_amt,
    input  logic [ACC_W-1:0]  acc_max,
    output logic [ACC_W-1:0]  acc_q,
    output logic [ACC_W-1:0]  acc_nxt
);
    import sem_pkg::*;

    localparam int SUM_W = ACC_W + 2;

    upd_kind_e               kind;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] cap;

    // Classify this cycle's update.
    always_comb kind = upd_kind_e'({add_i, leak_i});

    // Compute the raw sum and clamp it to both limits.
    always_comb begin
        sum = $signed({2'b00, acc_q});
        cap = $signed({2'b00, acc_max});
        case (kind)
            UPD_ADD:  sum = sum + SUM_W'(WEIGHT);
            UPD_LEAK: sum = sum - $signed(SUM_W'(leak_amt));
            UPD_BOTH: sum = sum + SUM_W'(WEIGHT) - $signed(SUM_W'(leak_amt));
            default:  sum = sum;
        endcase
        if (sum < 0)
            acc_nxt = '0;
        else if (sum > cap)
            acc_nxt = acc_max;
        else
            acc_nxt = sum[ACC_W-1:0];
    end

    // Commit the clamped value; reset empties the bucket.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_nxt;
    end
endmodule

// File: rtl/sem_hyst_flag.sv
// Two-level comparator with memory.
// Sets on level >= set_lvl and clears on level < clr_lvl.
// Setting wins if both hold.
// Assumes lvl is the value being committed on the same edge.
module sem_hyst_flag #(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] lvl,
    input  logic [ACC_W-1:0] set_lvl,
    input  logic [ACC_W-1:0] clr_lvl,
    output logic             flag_q
);
    // Update the flag; hold it between the two levels.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (lvl >= set_lvl) flag_q <= 1'b1;
        else if (lvl < clr_lvl)  flag_q <= 1'b0;
    end
endmodule

// File: rtl/sync_err_monitor.sv
// Sync error rate monitor: leaky bucket plus hysteresis flag.
// Assumes line_stb and sync_err are single-cycle pulses in the clk domain.
module sync_err_monitor #(
    parameter int ACC_W  = 8,
    parameter int LEAK_W = 4,
    parameter int WEIGHT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              sync_err,
    input  logic [LEAK_W-1:0] leak_amt,
    input  logic [ACC_W-1:0]  set_lvl,
    input  logic [ACC_W-1:0]  clr_lvl,
    input  logic [ACC_W-1:0]  acc_max,
    output logic              warn
);
    logic [ACC_W-1:0] acc_lvl;
    logic [ACC_W-1:0] acc_nxt;

    sem_bucket #(.ACC_W(ACC_W), .LEAK_W(LEAK_W), .WEIGHT(WEIGHT)) u_bucket (
        .clk(clk), .rst_n(rst_n), .add_i(sync_err), .leak_i(line_stb),
        .leak_amt(leak_amt), .acc_max(acc_max),
        .acc_q(acc_lvl), .acc_nxt(acc_nxt)
    );

    sem_hyst_flag #(.ACC_W(ACC_W)) u_flag (
        .clk(clk), .rst_n(rst_n), .lvl(acc_nxt),
        .set_lvl(set_lvl), .clr_lvl(clr_lvl), .flag_q(warn)
    );
endmodule

// File: rtl/sync_err_monitor_chk.sv
// Assertion checker bound to the monitor.
// It observes the committed accumulator and the flag.
module sync_err_monitor_chk #(
    parameter int ACC_W  = 8,
    parameter int LEAK_W = 4,
    parameter int WEIGHT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_stb,
    input logic              sync_err,
    input logic [ACC_W-1:0]  set_lvl,
    input logic [ACC_W-1:0]  clr_lvl,
    input logic [ACC_W-1:0]  acc_max,
    input logic [ACC_W-1:0]  acc_lvl,
    input logic              warn
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!warn && acc_lvl == '0));

    a_r2_err_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !line_stb && ({1'b0, acc_lvl} + (ACC_W+1)'(WEIGHT) <= {1'b0, acc_max}))
        |=> ({1'b0, acc_lvl} == {1'b0, $past(acc_lvl)} + (ACC_W+1)'(WEIGHT)));

    a_r3_leak_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !sync_err) |=> (acc_lvl <= $past(acc_lvl)));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (acc_lvl <= $past(acc_max)));

    a_r6_rise_at_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn) |-> ($past(rst_n) && acc_lvl >= $past(set_lvl)));

    a_r7_fall_below_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warn) |-> (acc_lvl < $past(clr_lvl)));
endmodule

bind sync_err_monitor sync_err_monitor_chk #(
    .ACC_W(ACC_W), .LEAK_W(LEAK_W), .WEIGHT(WEIGHT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .sync_err(sync_err),
    .set_lvl(set_lvl), .clr_lvl(clr_lvl), .acc_max(acc_max),
    .acc_lvl(acc_lvl), .warn(warn)
);

// File: tb/sync_err_monitor_tb.sv
module sync_err_monitor_tb;
    localparam int ACC_W  = 8;
    localparam int LEAK_W = 4;
    localparam int WEIGHT = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_stb = 1'b0;
    logic              sync_err = 1'b0;
    logic [LEAK_W-1:0] leak_amt = 4'd1;
    logic [ACC_W-1:0]  set_lvl = 8'd40;
    logic [ACC_W-1:0]  clr_lvl = 8'd25;
    logic [ACC_W-1:0]  acc_max = 8'd200;
    logic              warn;

    int n_vec = 0;
    int n_bad = 0;
    int m_acc = 0;
    bit m_flag = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sync_err_monitor #(.ACC_W(ACC_W), .LEAK_W(LEAK_W), .WEIGHT(WEIGHT)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .sync_err(sync_err),
        .leak_amt(leak_amt), .set_lvl(set_lvl), .clr_lvl(clr_lvl),
        .acc_max(acc_max), .warn(warn)
    );

    // Expected bucket value after one update, from R2 to R5.
    function automatic int model_acc(int a, bit e, bit l, int leak, int mx);
        int s = a + (e ? WEIGHT : 0) - (l ? leak : 0);
        if (s < 0)  s = 0;
        if (s > mx) s = mx;
        return s;
    endfunction

    // Expected flag from R6 to R8.
    function automatic bit model_flag(bit f, int a, int st, int cl);
        if (a >= st) return 1'b1;
        if (a < cl)  return 1'b0;
        return f;
    endfunction

    task automatic check(string tag);
        n_vec++;
        if (warn !== m_flag) begin
            n_bad++;
            $display("FAIL %s: warn=%0b expected %0b (model acc %0d)", tag, warn, m_flag, m_acc);
        end
    endtask

    // Drive one cycle at the falling edge, update the model at the rising edge, then check.
    task automatic step(bit e, bit l, string tag);
        @(negedge clk);
        sync_err = e;
        line_stb = l;
        @(posedge clk);
        if (!rst_n) begin
            m_acc = 0;
            m_flag = 1'b0;
        end else begin
            m_acc  = model_acc(m_acc, e, l, int'(leak_amt), int'(acc_max));
            m_flag = model_flag(m_flag, m_acc, int'(set_lvl), int'(clr_lvl));
        end
        #1;
        check(tag);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EC0_0D1E);

        // R1: reset state
        step(1'b1, 1'b0, "R1");
        step(1'b0, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R6: one error with set level 11 stays low, the next sets the flag.
        set_lvl = 8'd11;
        clr_lvl = 8'd5;
        step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, "R6");

        // R7: drain through the band; the flag holds until below 5.
        leak_amt = 4'd3;
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R7");

        // R3: floor at 0; a single error with set = WEIGHT then sets.
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R3");
        set_lvl = 8'(WEIGHT);
        clr_lvl = 8'(WEIGHT);
        step(1'b1, 1'b0, "R3");

        // R4: both inputs together give net 10 - 3 = 7 -> 17, then clears below 18.
        clr_lvl = 8'd18;
        set_lvl = 8'd30;
        step(1'b1, 1'b1, "R4");

        // R5: ceiling at 30; set 31 is never reached.
        acc_max = 8'd30;
        set_lvl = 8'd31;
        clr_lvl = 8'd0;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R5");
        set_lvl = 8'd30;
        step(1'b0, 1'b0, "R5");

        // Lowering the ceiling pulls the value down; probe with a clear level.
        acc_max = 8'd12;
        clr_lvl = 8'd13;
        step(1'b0, 1'b0, "R5");
        set_lvl = 8'd12;
        step(1'b0, 1'b0, "R5");

        // R8: inverted levels; setting wins.
        set_lvl = 8'd5;
        clr_lvl = 8'd50;
        step(1'b0, 1'b0, "R8");

        // Random rate mix at the default rate: weight 10, leak 1.
        acc_max  = 8'd120;
        set_lvl  = 8'd40;
        clr_lvl  = 8'd25;
        leak_amt = 4'd1;
        for (int i = 0; i < 3000; i++) begin
            int pe = (i / 500) % 2 == 0 ? 12 : 5;
            step(($urandom % 100) < pe, ($urandom % 4) == 0, "R7");
            if (($urandom % 400) == 0) leak_amt = 4'($urandom % 4);
        end

        // Reset during activity.
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b1, 1'b1, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule